// File: doc/BRIEF.md
# Energy-Based Pruning Level Controller

This block watches the coefficients of one 8x8 transform block as they stream past, one per clock in raster order. Each coefficient comes with its 6-bit position, row in the upper three bits and column in the lower three. The anti-diagonal `row + column` of a coefficient is its pruning level, from 0 (the DC term alone) to 14. The block squares every AC coefficient and sums the squares per level. As soon as the last coefficient of a level has been summed, the level's energy is compared with a programmable threshold. The first level whose energy falls below the threshold ends the block. The block then reports the level just before it, and a downstream quantizer or entropy coder stops at that diagonal.

A fixed mode skips the energy measurement. Each block then gets a user-chosen level, announced when its DC term passes through. In both modes every reported level comes with a single-cycle strobe.

Top module: `prune_level_ctrl`

## Requirements
- R1: A coefficient at position `{row[2:0], col[2:0]}` belongs to level `row+col`. Level d is complete when its last raster coefficient is accepted: position `8*d` for d up to 7, and row 7, column `d-7` for larger d.
- R2: Accepting the DC coefficient (position 0) clears the energy of levels 1 to 14, and the DC value adds to no level. Leftover energy from a previous block never affects the next one.
- R3: Each AC coefficient's square is added to its level's energy. Full-scale 12-bit signed inputs (-2048) at every position do not overflow any level's sum.
- R4: In automatic mode (`fixed_mode`=0), when level d completes with an energy strictly below the threshold, `lvl_out` = d-1. This is reported two cycles after the clock edge that accepted the completing coefficient. Level 1 below the threshold therefore reports 0.
- R5: In automatic mode, if no level falls below the threshold, `lvl_out` = 14. It is reported two cycles after position 63 is accepted.
- R6: A threshold of 0 never ends a block early, so every automatic block reports 14.
- R7: The threshold resets to 200. A cycle with `thr_we`=1 loads `thr_in`, which takes effect for later levels.
- R8: After a block reports its level, the rest of that block's coefficients are ignored. No further report occurs until the next DC coefficient.
- R9: In fixed mode, `lvl_out` = `fixed_level`, held to at most 14, two cycles after the DC coefficient is accepted. Energies never cause a report in fixed mode.
- R10: `lvl_valid` is a one-cycle pulse, asserted exactly once per block. `lvl_out` is never above 14 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_valid | input | 1 | A coefficient is present this cycle |
| coef_pos | input | 6 | Raster position: row in [5:3], column in [2:0] |
| coef_val | input | 12 | Signed coefficient value |
| thr_we | input | 1 | Load `thr_in` into the threshold register |
| thr_in | input | 12 | Unsigned energy threshold |
| fixed_mode | input | 1 | 1 selects fixed level, 0 automatic |
| fixed_level | input | 4 | Level reported in fixed mode |
| lvl_out | output | 4 | Reported pruning level |
| lvl_valid | output | 1 | One-cycle strobe qualifying `lvl_out` |

## Verification
The embedded properties assume a well-formed stream: each block starts with its DC coefficient, positions follow raster order without repeats, and `fixed_mode` holds steady across a block. The bench stays within these assumptions. It always drives complete 64-coefficient blocks starting at position 0, followed by idle cycles. It changes the threshold or the mode only in those idle gaps, after the previous block's report has left the pipeline.

// File: rtl/prune_level_ctrl.sv
module prune_level_ctrl #(
  parameter int CW = 12,
  parameter int TW = 12,
  parameter logic [TW-1:0] THR_RST = TW'(200)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_valid,
  input  logic [5:0]    coef_pos,
  input  logic [CW-1:0] coef_val,
  input  logic          thr_we,
  input  logic [TW-1:0] thr_in,
  input  logic          fixed_mode,
  input  logic [3:0]    fixed_level,
  output logic [3:0]    lvl_out,
  output logic          lvl_valid
);
  localparam int SQW = 2*CW - 1;
  localparam int EW  = SQW + 3;
  localparam logic [3:0] LMAX = 4'd14;

  logic [TW-1:0] thr;
  always_ff @(posedge clk)
    if (!rst_n)      thr <= THR_RST;
    else if (thr_we) thr <= thr_in;

  logic signed [2*CW-1:0] prod;
  logic [3:0] lvl_in;
  logic       last_in, dc_in;
  assign prod    = $signed(coef_val) * $signed(coef_val);
  assign lvl_in  = {1'b0, coef_pos[5:3]} + {1'b0, coef_pos[2:0]};
  assign dc_in   = (coef_pos == 6'd0);
  assign last_in = !dc_in && (coef_pos[2:0] == 3'd0 || coef_pos[5:3] == 3'd7);

  logic           s1_v, s1_dc, s1_last;
  logic [3:0]     s1_lvl;
  logic [SQW-1:0] s1_sq;
  always_ff @(posedge clk)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_dc <= 1'b0; s1_last <= 1'b0; s1_lvl <= '0; s1_sq <= '0;
    end else begin
      s1_v    <= coef_valid;
      s1_dc   <= dc_in;
      s1_last <= last_in;
      s1_lvl  <= lvl_in;
      s1_sq   <= prod[SQW-1:0];
    end

  logic [EW-1:0] en [0:15];
  logic          s2_v, s2_dc, s2_chk;
  logic [3:0]    s2_lvl;
  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) en[i] <= '0;
      s2_v <= 1'b0; s2_dc <= 1'b0; s2_chk <= 1'b0; s2_lvl <= '0;
    end else begin
      if (s1_v && s1_dc)
        for (int i = 0; i < 16; i++) en[i] <= '0;
      else if (s1_v)
        en[s1_lvl] <= en[s1_lvl] + EW'(s1_sq);
      s2_v   <= s1_v;
      s2_dc  <= s1_dc;
      s2_chk <= s1_last;
      s2_lvl <= s1_lvl;
    end

  logic low, done;
  assign low = en[s2_lvl] < EW'(thr);

  always_ff @(posedge clk)
    if (!rst_n) begin
      lvl_out <= '0; lvl_valid <= 1'b0; done <= 1'b1;
    end else begin
      lvl_valid <= 1'b0;
      if (s2_v && s2_dc) begin
        done <= 1'b0;
        if (fixed_mode) begin
          lvl_valid <= 1'b1;
          lvl_out   <= (fixed_level > LMAX) ? LMAX : fixed_level;
        end
      end else if (s2_v && s2_chk && !done && !fixed_mode) begin
        if (low) begin
          lvl_valid <= 1'b1; lvl_out <= s2_lvl - 4'd1; done <= 1'b1;
        end else if (s2_lvl == LMAX) begin
          lvl_valid <= 1'b1; lvl_out <= LMAX; done <= 1'b1;
        end
      end
    end

  p_dc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_dc) |=> (en[1] == '0 && en[14] == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_dc) |=> (en[$past(s1_lvl)] >= EW'($past(s1_sq))));

  p_thr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (thr == $past(thr_in)));

  p_single_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_valid && !fixed_mode) |=> !(lvl_valid && !fixed_mode));

  p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> (lvl_out <= LMAX));
endmodule

// File: tb/test_prune_level_ctrl.sv
module test_prune_level_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coef_valid = 1'b0;
  logic [5:0]  coef_pos = '0;
  logic [11:0] coef_val = '0;
  logic        thr_we = 1'b0;
  logic [11:0] thr_in = '0;
  logic        fixed_mode = 1'b0;
  logic [3:0]  fixed_level = '0;
  logic [3:0]  lvl_out;
  logic        lvl_valid;

  always #4 clk = ~clk;

  prune_level_ctrl i_prune_level_ctrl (
    .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_pos(coef_pos),
    .coef_val(coef_val), .thr_we(thr_we), .thr_in(thr_in),
    .fixed_mode(fixed_mode), .fixed_level(fixed_level),
    .lvl_out(lvl_out), .lvl_valid(lvl_valid));

  typedef struct packed { int lo; int k; int hi; int thr; int fm; int fl; } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{10, 3, 0, 200, 0, 0},
    '{5, 14, 5, 200, 0, 0},
    '{50, 14, 50, 4095, 0, 0},
    '{0, 14, 0, 0, 0, 0},
    '{100, 14, 100, 200, 1, 5},
    '{0, 14, 0, 200, 1, 15},
    '{-2048, 14, -2048, 4095, 0, 0},
    '{8, 6, 0, 100, 0, 0},
    '{1, 1, 1000, 200, 0, 0},
    '{30, 9, 0, 500, 0, 0}
  };

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int last_idx(input int d);
    return (d <= 7) ? 8*d : 56 + d - 7;
  endfunction

  task automatic set_thr(input int t);
    @(negedge clk);
    thr_we = 1'b1; thr_in = 12'(t);
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic run_block(input vec_t v, input int thr, input string req);
    int pulses = 0;
    int step = -1;
    int pl = -1;
    int term = 14;
    int exp_pl, exp_step;
    for (int d = 1; d <= 14; d++) begin
      longint a = (d <= v.k) ? v.lo : v.hi;
      longint e = longint'((d <= 7) ? d + 1 : 15 - d) * a * a;
      if (e < thr) begin term = d; break; end
    end
    if (v.fm != 0) begin
      exp_pl = (v.fl > 14) ? 14 : v.fl; exp_step = 3;
    end else begin
      exp_pl = (term < 14 || (term == 14 && thr > 0 &&
                ((v.k >= 14 ? v.lo : v.hi) * (v.k >= 14 ? v.lo : v.hi)) < thr)) ? term - 1 : 14;
      exp_step = last_idx(term) + 3;
    end
    fixed_mode = (v.fm != 0);
    fixed_level = 4'(v.fl);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (lvl_valid) begin
        pulses++;
        if (step < 0) begin step = i; pl = int'(lvl_out); end
      end
      if (i < 64) begin
        int d = i / 8 + i % 8;
        coef_valid = 1'b1;
        coef_pos = 6'(i);
        coef_val = (i == 0) ? 12'sd2047 : 12'((d <= v.k) ? v.lo : v.hi);
      end else begin
        coef_valid = 1'b0;
      end
    end
    check(pulses == 1, {req, " R10 single pulse"}, pulses, 1);
    check(pl == exp_pl, {req, " level"}, pl, exp_pl);
    check(step == exp_step, {req, " R1 timing"}, step, exp_step);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lvl_valid == 1'b0, "R10 reset valid", int'(lvl_valid), 0);
    check(lvl_out == 4'd0, "R10 reset level", int'(lvl_out), 0);
    rst_n = 1'b1;
    // R7: default threshold 200 without any write
    run_block('{9, 3, 0, 0, 0, 0}, 200, "R7 default e1=162");
    run_block('{10, 3, 0, 0, 0, 0}, 200, "R7 default e1=200");
    for (int n = 0; n < NV; n++) begin
      string tag;
      set_thr(VECS[n].thr);
      case (n)
        0: tag = "R4 stop at level 4";
        1: tag = "R4 level1 low";
        2: tag = "R4 level 14 low";
        3: tag = "R6 zero threshold";
        4: tag = "R9 fixed level";
        5: tag = "R9 fixed clamp";
        6: tag = "R3 full scale R5";
        7: tag = "R2 cleared after large block";
        8: tag = "R8 ignore after stop";
        default: tag = "R1 upper diagonal";
      endcase
      run_block(VECS[n], VECS[n].thr, tag);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule